// File: doc/BRIEF.md
# Multiplexed-Address Machine Cycle Sequencer

This block produces the memory-bus timing of an 8-bit processor whose 16-bit address leaves on only eight address lines. Every machine cycle lasts a fixed eight input clocks. Within a cycle the upper address byte is presented first and the lower byte second. A latch strobe lets external logic capture the upper byte, and a second strobe marks the late part of the cycle. The block also drives an active-low read enable, an active-low write strobe and a 2-bit cycle code.

The sequencer runs a fetch cycle, then one execute cycle, or two when the core flags a long instruction. The core supplies the address, the write request and the long flag. The block samples all three once per cycle, on the clock edge that ends the last clock of the current cycle. The sampled values govern the cycle that follows. A synchronous clear restarts the sequence at the first clock of a fetch cycle.

Top module: `mcyc_seq`

## Requirements
- R1: Every machine cycle is exactly eight clocks, numbered 0 to 7. `take_o` is high during clock 7 only, so it is high once in every eight clocks.
- R2: `abus_o` carries address bits [15:8] during clocks 0 and 1. It carries bits [7:0] during clocks 2 to 7.
- R3: `hi_stb_o` is high during clock 1 of every cycle and low in every other clock.
- R4: `late_stb_o` is high during clock 6 of every cycle and low in every other clock.
- R5: In a read cycle, `rd_n_o` is low from clock 1 through clock 7 and high in clock 0. In a write cycle it stays high for all eight clocks.
- R6: `wr_n_o` is low during clock 6 of a write execute cycle and high in every other clock. It is never low while `rd_n_o` is low.
- R7: `code_o` is 2'b00 for a fetch cycle and 2'b01 for an execute cycle. It changes only at a cycle boundary.
- R8: Fetch is followed by one execute cycle, then fetch again. When `core_long` is sampled high at the end of a fetch, two execute cycles follow before the next fetch.
- R9: `core_addr`, `core_wr` and `core_long` are sampled only on the edge that ends clock 7. They set the address, the direction and (after a fetch) the execute count of the next cycle. Their values at any other edge have no effect.
- R10: A fetch cycle is always a read: `core_wr` has no effect when the next cycle is a fetch.
- R11: While `clr` is high at a clock edge, the next clock is clock 0 of a fetch cycle with address 0. In that clock `hi_stb_o`, `late_stb_o` and `take_o` are low, `rd_n_o` and `wr_n_o` are high, and `abus_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; one machine cycle is eight periods |
| clr | input | 1 | Synchronous active-high clear |
| core_addr | input | 16 | Address for the next machine cycle |
| core_wr | input | 1 | Next execute cycle is a memory write |
| core_long | input | 1 | Sampled at fetch end: two execute cycles follow |
| abus_o | output | 8 | Multiplexed address byte, upper then lower |
| hi_stb_o | output | 1 | Upper-byte latch strobe, high in clock 1 |
| late_stb_o | output | 1 | Late-cycle strobe, high in clock 6 |
| rd_n_o | output | 1 | Active-low memory read enable |
| wr_n_o | output | 1 | Active-low memory write strobe |
| code_o | output | 2 | Cycle code: 00 fetch, 01 execute |
| take_o | output | 1 | High in clock 7, the clock whose ending edge samples the core inputs |

## Verification
A wrong phase count shows within one clock on `take_o` and on both strobes, and the bench compares every output on every clock. A wrong cycle kind or a lost execute count shows on `code_o` from clock 0 of the affected cycle. A direction error shows one clock later on `rd_n_o`, and a write-strobe error by clock 6 of that cycle. A wrongly captured address shows on `abus_o` in clock 0, and in the low byte from clock 2. The inputs are deliberately scrambled outside clock 7, so capture at any other edge surfaces in the next cycle's address or kind.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  typedef enum logic [1:0] {
    CK_FETCH = 2'b00,
    CK_EXEC  = 2'b01,
    CK_DMA   = 2'b10,
    CK_INTR  = 2'b11
  } cyc_kind_e;
endpackage

// File: rtl/mcs_phase_ctr.sv
module mcs_phase_ctr #(
  parameter int CLKS = 8,
  localparam int PH_W = $clog2(CLKS)
) (
  input  logic            clk,
  input  logic            clr,
  output logic [PH_W-1:0] ph_nxt,
  output logic            at_end
);
  localparam logic [PH_W-1:0] P_LAST = PH_W'(CLKS - 1);

  logic [PH_W-1:0] ph_q;

  assign at_end = (ph_q == P_LAST);

  always_comb begin
    if (clr || at_end) ph_nxt = '0;
    else               ph_nxt = ph_q + 1'b1;
  end

  always_ff @(posedge clk) ph_q <= ph_nxt;
endmodule

// File: rtl/mcs_kind_seq.sv
module mcs_kind_seq
  import mcs_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int EXEC_LONG = 2,
  localparam int LEFT_W   = (EXEC_LONG > 2) ? $clog2(EXEC_LONG) : 1
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              at_end,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic              core_wr,
  input  logic              core_long,
  output cyc_kind_e         kind_nxt,
  output logic [ADDR_W-1:0] addr_nxt,
  output logic              wr_nxt
);
  cyc_kind_e         kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [LEFT_W-1:0] left_q, left_nxt;

  always_comb begin
    kind_nxt = kind_q;
    addr_nxt = addr_q;
    wr_nxt   = wr_q;
    left_nxt = left_q;
    if (clr) begin
      kind_nxt = CK_FETCH;
      addr_nxt = '0;
      wr_nxt   = 1'b0;
      left_nxt = '0;
    end else if (at_end) begin
      addr_nxt = core_addr;
      if (kind_q == CK_FETCH) begin
        kind_nxt = CK_EXEC;
        left_nxt = core_long ? LEFT_W'(EXEC_LONG - 1) : '0;
      end else if (left_q != '0) begin
        kind_nxt = CK_EXEC;
        left_nxt = left_q - 1'b1;
      end else begin
        kind_nxt = CK_FETCH;
      end
      wr_nxt = core_wr && (kind_nxt == CK_EXEC);
    end
  end

  always_ff @(posedge clk) begin
    kind_q <= kind_nxt;
    addr_q <= addr_nxt;
    wr_q   <= wr_nxt;
    left_q <= left_nxt;
  end
endmodule

// File: rtl/mcs_strobe_gen.sv
module mcs_strobe_gen
  import mcs_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int BUS_W   = 8,
  parameter int CLKS    = 8,
  parameter int HI_CLKS = 2,
  parameter int STA_CLK = 1,
  parameter int STB_CLK = 6,
  parameter int WR_CLK  = 6,
  parameter int RD_CLK  = 1,
  localparam int PH_W   = $clog2(CLKS)
) (
  input  logic              clk,
  input  logic              clr,
  input  logic [PH_W-1:0]   ph_nxt,
  input  cyc_kind_e         kind_nxt,
  input  logic [ADDR_W-1:0] addr_nxt,
  input  logic              wr_nxt,
  output logic [BUS_W-1:0]  abus_q,
  output logic              hi_q,
  output logic              late_q,
  output logic              rd_n_q,
  output logic              wr_n_q,
  output logic [1:0]        code_q,
  output logic              take_q
);
  localparam logic [PH_W-1:0] P_HI   = PH_W'(HI_CLKS);
  localparam logic [PH_W-1:0] P_STA  = PH_W'(STA_CLK);
  localparam logic [PH_W-1:0] P_STB  = PH_W'(STB_CLK);
  localparam logic [PH_W-1:0] P_WR   = PH_W'(WR_CLK);
  localparam logic [PH_W-1:0] P_RD   = PH_W'(RD_CLK);
  localparam logic [PH_W-1:0] P_LAST = PH_W'(CLKS - 1);

  logic [BUS_W-1:0] byte_sel;

  always_comb begin
    if (ph_nxt < P_HI) byte_sel = addr_nxt[ADDR_W-1 -: BUS_W];
    else               byte_sel = addr_nxt[BUS_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      abus_q <= '0;
      hi_q   <= 1'b0;
      late_q <= 1'b0;
      rd_n_q <= 1'b1;
      wr_n_q <= 1'b1;
      code_q <= CK_FETCH;
      take_q <= 1'b0;
    end else begin
      abus_q <= byte_sel;
      hi_q   <= (ph_nxt == P_STA);
      late_q <= (ph_nxt == P_STB);
      rd_n_q <= !((ph_nxt >= P_RD) && !wr_nxt);
      wr_n_q <= !((ph_nxt == P_WR) && wr_nxt);
      code_q <= kind_nxt;
      take_q <= (ph_nxt == P_LAST);
    end
  end
endmodule

// File: rtl/mcyc_seq.sv
module mcyc_seq
  import mcs_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BUS_W     = 8,
  parameter int CLKS      = 8,
  parameter int EXEC_LONG = 2,
  localparam int PH_W     = $clog2(CLKS)
) (
  input  logic              clk,
  input  logic              clr,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic              core_wr,
  input  logic              core_long,
  output logic [BUS_W-1:0]  abus_o,
  output logic              hi_stb_o,
  output logic              late_stb_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic [1:0]        code_o,
  output logic              take_o
);
  logic [PH_W-1:0]   ph_nxt;
  logic              at_end;
  cyc_kind_e         kind_nxt;
  logic [ADDR_W-1:0] addr_nxt;
  logic              wr_nxt;

  mcs_phase_ctr #(.CLKS(CLKS)) u_ph (
    .clk(clk), .clr(clr), .ph_nxt(ph_nxt), .at_end(at_end)
  );

  mcs_kind_seq #(.ADDR_W(ADDR_W), .EXEC_LONG(EXEC_LONG)) u_kind (
    .clk(clk), .clr(clr), .at_end(at_end),
    .core_addr(core_addr), .core_wr(core_wr), .core_long(core_long),
    .kind_nxt(kind_nxt), .addr_nxt(addr_nxt), .wr_nxt(wr_nxt)
  );

  mcs_strobe_gen #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .CLKS(CLKS)) u_stb (
    .clk(clk), .clr(clr), .ph_nxt(ph_nxt), .kind_nxt(kind_nxt),
    .addr_nxt(addr_nxt), .wr_nxt(wr_nxt),
    .abus_q(abus_o), .hi_q(hi_stb_o), .late_q(late_stb_o),
    .rd_n_q(rd_n_o), .wr_n_q(wr_n_o), .code_q(code_o), .take_q(take_o)
  );
endmodule

// File: rtl/mcs_chk.sv
module mcs_chk (
  input logic       clk,
  input logic       clr,
  input logic       hi_stb_o,
  input logic       late_stb_o,
  input logic       rd_n_o,
  input logic       wr_n_o,
  input logic [1:0] code_o,
  input logic       take_o
);
  logic [3:0] gap = '0;

  always_ff @(posedge clk) begin
    if (clr || take_o) gap <= '0;
    else               gap <= gap + 1'b1;
  end

  a_r1_take_period: assert property (@(posedge clk) disable iff (clr)
    take_o |-> (gap == 4'd7));
  a_r1_gap_bound: assert property (@(posedge clk) disable iff (clr)
    gap <= 4'd7);
  a_r3_hi_single: assert property (@(posedge clk) disable iff (clr)
    hi_stb_o |=> !hi_stb_o);
  a_r4_late_before_take: assert property (@(posedge clk) disable iff (clr)
    late_stb_o |=> take_o);
  a_r6_wr_in_late: assert property (@(posedge clk) disable iff (clr)
    !wr_n_o |-> (late_stb_o && rd_n_o));
  a_r7_code_steady: assert property (@(posedge clk) disable iff (clr)
    !take_o |=> $stable(code_o));
  a_r10_fetch_no_write: assert property (@(posedge clk) disable iff (clr)
    (code_o == 2'b00) |-> wr_n_o);
  a_r11_clear_idle: assert property (@(posedge clk)
    clr |=> (!hi_stb_o && !late_stb_o && !take_o && rd_n_o && wr_n_o && code_o == 2'b00));
endmodule

bind mcyc_seq mcs_chk u_chk (
  .clk(clk), .clr(clr), .hi_stb_o(hi_stb_o), .late_stb_o(late_stb_o),
  .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .code_o(code_o), .take_o(take_o)
);

// File: tb/sim_mcyc_seq.sv
`timescale 1ns/1ps
module sim_mcyc_seq;
  logic        clk = 1'b0;
  logic        clr = 1'b1;
  logic [15:0] core_addr = '0;
  logic        core_wr = 1'b0;
  logic        core_long = 1'b0;
  logic [7:0]  abus_o;
  logic        hi_stb_o, late_stb_o, rd_n_o, wr_n_o, take_o;
  logic [1:0]  code_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  int          m_k;
  logic [1:0]  m_kind;
  logic [15:0] m_addr;
  logic        m_wr;
  int          m_left;
  int          ncyc;

  always #10 clk = ~clk;

  mcyc_seq u0 (
    .clk(clk), .clr(clr), .core_addr(core_addr), .core_wr(core_wr),
    .core_long(core_long), .abus_o(abus_o), .hi_stb_o(hi_stb_o),
    .late_stb_o(late_stb_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o),
    .code_o(code_o), .take_o(take_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s clock=%0d actual=%0h expected=%0h", req, m_k, act, exp);
    end
  endtask

  task automatic chk_idle();
    chk("R11 hi", int'(hi_stb_o), 0);
    chk("R11 late", int'(late_stb_o), 0);
    chk("R11 take", int'(take_o), 0);
    chk("R11 rd_n", int'(rd_n_o), 1);
    chk("R11 wr_n", int'(wr_n_o), 1);
    chk("R11 abus", int'(abus_o), 0);
    chk("R11 code", int'(code_o), 0);
  endtask

  task automatic model_reset();
    m_k = 0; m_kind = 2'b00; m_addr = '0; m_wr = 1'b0; m_left = 0;
  endtask

  task automatic chk_all();
    chk("R1 take", int'(take_o), (m_k == 7) ? 1 : 0);
    chk("R2 abus", int'(abus_o), (m_k < 2) ? int'(m_addr[15:8]) : int'(m_addr[7:0]));
    chk("R3 hi_stb", int'(hi_stb_o), (m_k == 1) ? 1 : 0);
    chk("R4 late_stb", int'(late_stb_o), (m_k == 6) ? 1 : 0);
    chk("R5 rd_n", int'(rd_n_o), (m_k >= 1 && !m_wr) ? 0 : 1);
    chk("R6 wr_n", int'(wr_n_o), (m_k == 6 && m_wr) ? 0 : 1);
    chk("R7 R8 code", int'(code_o), int'(m_kind));
  endtask

  initial begin
    logic [15:0] a;
    logic        w, l;
    model_reset();
    ncyc = 0;
    repeat (3) @(negedge clk);
    chk_idle();
    clr = 1'b0;
    for (int step = 0; step < 4000; step++) begin
      chk_all();
      if (step == 1812) begin
        // R11: clear in the middle of a cycle
        clr = 1'b1;
        @(negedge clk);
        model_reset();
        chk_idle();
        clr = 1'b0;
        continue;
      end
      a = 16'(ncyc * 16'h1357 + 16'h00A5);
      w = ncyc[1] ^ ncyc[3];
      l = (ncyc % 3) == 0;
      if (m_k == 7) begin
        core_addr = a; core_wr = w; core_long = l;
      end else begin
        // R9: values away from clock 7 must be ignored
        core_addr = ~a ^ 16'(step); core_wr = ~w; core_long = ~l;
      end
      @(negedge clk);
      if (m_k == 7) begin
        if (m_kind == 2'b00) begin
          m_kind = 2'b01; m_left = l ? 1 : 0;
        end else if (m_left > 0) begin
          m_kind = 2'b01; m_left--;
        end else begin
          m_kind = 2'b00;
        end
        m_addr = a;
        m_wr = w && (m_kind == 2'b01); // R10: fetch never writes
        m_k = 0;
        ncyc++;
      end else begin
        m_k++;
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule